// File: doc/BRIEF.md
# Threshold Data FIFO with Block Counting

This block is a 32-word by 16-bit queue between a processor or DMA word port and a card data path that moves one byte at a time. In the card-to-host direction, incoming bytes are paired into words. The first byte of a pair goes into the low half and the second into the high half. In the host-to-card direction, each word is split and sent low byte first. Two programmable levels, almost-full and almost-empty, watch the queue occupancy. Each crossing is steered either to a DMA request line or to a status flag, depending on a per-direction enable.

A transfer begins with a start pulse. The pulse empties the queue and latches the direction (1 means card to host). It also loads the block length and the block count, each given as value minus one. A byte counter runs down once per byte. When it reaches zero it reloads, and the block counter steps down. A block may end on an odd byte. In that case the final word holds a single byte, or a single byte is taken from the final word. When the last block completes, a one-cycle done pulse is raised and the engine goes idle.

The card engine is a five-state machine. `ST_IDLE` waits for a start. The start pulse moves it to `ST_RX_LO` in the card-to-host direction, or to `ST_TX_LO` in the host-to-card direction. A low-byte beat that does not end a block moves `ST_RX_LO` to `ST_RX_HI`, or `ST_TX_LO` to `ST_TX_HI`. A low-byte beat that ends a block, but not the transfer, stays in the low state. A high-byte beat returns `ST_RX_HI` to `ST_RX_LO`, or `ST_TX_HI` to `ST_TX_LO`. Any beat that ends the final block returns to `ST_IDLE`. A new start overrides every state.

Top module: `xfer_fifo`

## Requirements
- R1: After reset, no DMA request, status flag, done pulse, card `card_tx_valid` or card `card_rx_ready` is asserted. The levels reset to almost-full 31 and almost-empty 0, with both DMA enables off.
- R2: The queue keeps words in order, up to 32. A processor push made while 32 words are queued is dropped.
- R3: `cpu_rdata` always shows the head word. A pop while the queue is empty changes nothing, so the same word stays visible.
- R4: A `cfg_load` pulse takes four fields from `cfg_word`. Bit 15 is the receive DMA enable, bits 12:8 are the almost-full level, bit 7 is the transmit DMA enable and bits 4:0 are the almost-empty level. The new values take effect from the next cycle.
- R5: In the card-to-host direction, occupancy above the almost-full level raises `rx_dma_req` when receive DMA is enabled, and raises `buf_af_flag` otherwise. Both drop once occupancy is at or below the level.
- R6: In the host-to-card direction, occupancy below the almost-empty level raises `tx_dma_req` when transmit DMA is enabled, and raises `buf_ae_flag` otherwise. Both drop once occupancy is at or above the level.
- R7: With no transfer active and the queue empty, all four threshold outputs are low.
- R8: In the card-to-host direction, byte k of a block (counting from 0) lands in the low half of a word when k is even and in the high half when k is odd. A block of odd length ends with a word whose high half is zero.
- R9: In the host-to-card direction, each word is sent low byte then high byte. In a block of odd length, the last word sends only its low byte and is then removed from the queue.
- R10: `xfer_done` is high for exactly one cycle, the cycle after the last byte of the last block is handshaked. After that, the card port is idle.
- R11: A new card-to-host word is started only while occupancy is at or below the almost-full level. `card_tx_valid` is low while the queue is empty.
- R12: A start pulse empties the queue and latches `xfer_dir`. Processor pushes and pops made in the same cycle are discarded.
- R13: While a card-to-host transfer is active, processor pushes are ignored. While a host-to-card transfer is active, processor pops are ignored.
- R14: While `card_tx_valid` is high and `card_tx_ready` is low, the offered byte stays unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the threshold configuration word |
| cfg_word | input | 16 | Threshold configuration (layout in R4) |
| blk_len_m1 | input | 11 | Bytes per block minus one, sampled on start |
| blk_num_m1 | input | 11 | Blocks per transfer minus one, sampled on start |
| xfer_start | input | 1 | Start pulse: empty queue, latch direction and counts |
| xfer_dir | input | 1 | Direction sampled on start; 1 = card to host |
| cpu_push | input | 1 | Processor word push |
| cpu_wdata | input | 16 | Word to push |
| cpu_pop | input | 1 | Processor word pop |
| cpu_rdata | output | 16 | Head word of the queue |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_byte | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_byte | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| buf_af_flag | output | 1 | Almost-full status flag |
| buf_ae_flag | output | 1 | Almost-empty status flag |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume three things about the environment. The card keeps its byte handshake legal. The processor pops only through the gated port. No push reaches a full queue unless a start clears it in the same cycle. The bench stays within these limits because it drives every input at the falling edge, and it issues card bytes only through the valid/ready handshake. Random block lengths and counts, random data and random ready patterns are combined with directed cases. The directed cases cover the 33rd push, the pop from an empty queue, single-byte blocks, a fill held back by the almost-full level, and processor accesses injected into the wrong direction.

// File: rtl/xf_pkg.sv
package xf_pkg;

    localparam int unsigned XF_LVL_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_LO,
        ST_RX_HI,
        ST_TX_LO,
        ST_TX_HI
    } xf_state_e;

    typedef struct packed {
        logic                rx_dma_en;
        logic [XF_LVL_W-1:0] full_lvl;
        logic                tx_dma_en;
        logic [XF_LVL_W-1:0] empty_lvl;
    } xf_cfg_t;

endpackage

// File: rtl/xf_store.sv
module xf_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      occ <= occ + CW'(1);
            else if (pop && !push) occ <= occ - CW'(1);
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (occ == CW'(DEPTH));
    assign empty = (occ == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !clr |-> !full); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !clr |-> !empty); // R3

    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (occ == $past(occ)) || (occ == $past(occ) + CW'(1))
                 || (occ + CW'(1) == $past(occ))); // R2

endmodule

// File: rtl/xf_thresh.sv
module xf_thresh
    import xf_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [15:0]         cfg_word,
    input  logic                active,
    input  logic                dir,
    input  logic [CW-1:0]       occ,
    output logic [XF_LVL_W-1:0] full_lvl,
    output logic                rx_req,
    output logic                tx_req,
    output logic                af_flag,
    output logic                ae_flag
);

    xf_cfg_t cfg_q;
    logic    live;
    logic    over;
    logic    under;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.rx_dma_en <= 1'b0;
            cfg_q.full_lvl  <= '1;
            cfg_q.tx_dma_en <= 1'b0;
            cfg_q.empty_lvl <= '0;
        end else if (cfg_load) begin
            cfg_q.rx_dma_en <= cfg_word[15];
            cfg_q.full_lvl  <= cfg_word[12:8];
            cfg_q.tx_dma_en <= cfg_word[7];
            cfg_q.empty_lvl <= cfg_word[4:0];
        end
    end

    always_comb begin
        live    = active || (occ != '0);
        over    = live && dir && (occ > CW'(cfg_q.full_lvl));
        under   = live && !dir && (occ < CW'(cfg_q.empty_lvl));
        rx_req  = over && cfg_q.rx_dma_en;
        af_flag = over && !cfg_q.rx_dma_en;
        tx_req  = under && cfg_q.tx_dma_en;
        ae_flag = under && !cfg_q.tx_dma_en;
    end

    assign full_lvl = cfg_q.full_lvl;

endmodule

// File: rtl/xf_engine.sv
module xf_engine
    import xf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LEN_W = 11,
    parameter int CW    = 6,
    localparam int BC_W = LEN_W + 1,
    localparam int BW   = DW / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_dir,
    input  logic [LEN_W-1:0]    len_m1,
    input  logic [LEN_W-1:0]    num_m1,
    input  logic [XF_LVL_W-1:0] full_lvl,
    input  logic [CW-1:0]       occ,
    input  logic                full,
    input  logic                empty,
    input  logic [DW-1:0]       head,
    input  logic                rx_valid,
    input  logic [BW-1:0]       rx_byte,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [BW-1:0]       tx_byte,
    input  logic                tx_ready,
    output logic                wr_en,
    output logic [DW-1:0]       wr_data,
    output logic                rd_en,
    output logic                active,
    output logic                dir,
    output logic                done
);

    xf_state_e   state_q, state_d;
    logic [BC_W-1:0] len_q, num_q, bcnt_q, ncnt_q;
    logic [BW-1:0]   lo_q;
    logic        rx_fire, tx_fire, byte_fire, last_byte, last_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RX_LO: if (rx_fire) state_d = last_blk ? ST_IDLE
                                           : (last_byte ? ST_RX_LO : ST_RX_HI);
            ST_RX_HI: if (rx_fire) state_d = last_blk ? ST_IDLE : ST_RX_LO;
            ST_TX_LO: if (tx_fire) state_d = last_blk ? ST_IDLE
                                           : (last_byte ? ST_TX_LO : ST_TX_HI);
            ST_TX_HI: if (tx_fire) state_d = last_blk ? ST_IDLE : ST_TX_LO;
            default:  state_d = ST_IDLE;
        endcase
        if (start) state_d = start_dir ? ST_RX_LO : ST_TX_LO;
    end

    always_comb begin
        rx_ready  = ((state_q == ST_RX_LO) && (occ <= CW'(full_lvl)) && !full)
                 || ((state_q == ST_RX_HI) && !full);
        tx_valid  = ((state_q == ST_TX_LO) || (state_q == ST_TX_HI)) && !empty;
        tx_byte   = (state_q == ST_TX_HI) ? head[DW-1:BW] : head[BW-1:0];
        rx_fire   = rx_valid && rx_ready;
        tx_fire   = tx_valid && tx_ready;
        byte_fire = rx_fire || tx_fire;
        last_byte = byte_fire && (bcnt_q == BC_W'(1));
        last_blk  = last_byte && (ncnt_q == BC_W'(1));
        wr_en     = rx_fire && ((state_q == ST_RX_HI) || last_byte);
        wr_data   = (state_q == ST_RX_HI) ? {rx_byte, lo_q} : {{BW{1'b0}}, rx_byte};
        rd_en     = tx_fire && ((state_q == ST_TX_HI) || last_byte);
        active    = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            num_q  <= '0;
            bcnt_q <= '0;
            ncnt_q <= '0;
            lo_q   <= '0;
            dir    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= last_blk && !start;
            if (start) begin
                len_q  <= BC_W'(len_m1) + BC_W'(1);
                num_q  <= BC_W'(num_m1) + BC_W'(1);
                bcnt_q <= BC_W'(len_m1) + BC_W'(1);
                ncnt_q <= BC_W'(num_m1) + BC_W'(1);
                dir    <= start_dir;
            end else if (byte_fire) begin
                if (last_byte) begin
                    bcnt_q <= len_q;
                    ncnt_q <= last_blk ? num_q : ncnt_q - BC_W'(1);
                end else begin
                    bcnt_q <= bcnt_q - BC_W'(1);
                end
            end
            if (rx_fire && (state_q == ST_RX_LO)) lo_q <= rx_byte;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !start |=> tx_valid && $stable(tx_byte)); // R14

    AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |-> !full); // R11

endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
    import xf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int LEN_W = 11,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = DW / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [15:0]      cfg_word,
    input  logic [LEN_W-1:0] blk_len_m1,
    input  logic [LEN_W-1:0] blk_num_m1,
    input  logic             xfer_start,
    input  logic             xfer_dir,
    input  logic             cpu_push,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_pop,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             card_rx_valid,
    input  logic [BW-1:0]    card_rx_byte,
    output logic             card_rx_ready,
    output logic             card_tx_valid,
    output logic [BW-1:0]    card_tx_byte,
    input  logic             card_tx_ready,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             buf_af_flag,
    output logic             buf_ae_flag,
    output logic             xfer_done
);

    logic                q_push, q_pop, q_full, q_empty;
    logic [DW-1:0]       q_wdata, q_head;
    logic [CW-1:0]       q_occ;
    logic                eng_wr, eng_rd, eng_active, eng_dir;
    logic [DW-1:0]       eng_wdata;
    logic [XF_LVL_W-1:0] lvl_full;
    logic                cpu_push_ok, cpu_pop_ok;

    always_comb begin
        cpu_push_ok = cpu_push && !q_full && !(eng_active && eng_dir);
        cpu_pop_ok  = cpu_pop && !q_empty && !(eng_active && !eng_dir);
        q_push      = eng_wr || cpu_push_ok;
        q_wdata     = eng_wr ? eng_wdata : cpu_wdata;
        q_pop       = eng_rd || cpu_pop_ok;
    end

    assign cpu_rdata = q_head;

    xf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (xfer_start),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .head  (q_head),
        .occ   (q_occ),
        .full  (q_full),
        .empty (q_empty)
    );

    xf_thresh #(.CW(CW)) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .active   (eng_active),
        .dir      (eng_dir),
        .occ      (q_occ),
        .full_lvl (lvl_full),
        .rx_req   (rx_dma_req),
        .tx_req   (tx_dma_req),
        .af_flag  (buf_af_flag),
        .ae_flag  (buf_ae_flag)
    );

    xf_engine #(.DW(DW), .LEN_W(LEN_W), .CW(CW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .start_dir (xfer_dir),
        .len_m1    (blk_len_m1),
        .num_m1    (blk_num_m1),
        .full_lvl  (lvl_full),
        .occ       (q_occ),
        .full      (q_full),
        .empty     (q_empty),
        .head      (q_head),
        .rx_valid  (card_rx_valid),
        .rx_byte   (card_rx_byte),
        .rx_ready  (card_rx_ready),
        .tx_valid  (card_tx_valid),
        .tx_byte   (card_tx_byte),
        .tx_ready  (card_tx_ready),
        .wr_en     (eng_wr),
        .wr_data   (eng_wdata),
        .rd_en     (eng_rd),
        .active    (eng_active),
        .dir       (eng_dir),
        .done      (xfer_done)
    );

    AST_RX_DIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req || buf_af_flag |-> !(tx_dma_req || buf_ae_flag)); // R5

endmodule

// File: tb/test_xfer_fifo.sv
module test_xfer_fifo;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [10:0] blk_len_m1 = '0;
    logic [10:0] blk_num_m1 = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_dir = 1'b0;
    logic        cpu_push = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_pop = 1'b0;
    logic [15:0] cpu_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_byte = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_byte;
    logic        card_tx_ready = 1'b0;
    logic        rx_dma_req, tx_dma_req, buf_af_flag, buf_ae_flag, xfer_done;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_fifo i_xfer_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .blk_len_m1(blk_len_m1), .blk_num_m1(blk_num_m1),
        .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .cpu_push(cpu_push), .cpu_wdata(cpu_wdata), .cpu_pop(cpu_pop),
        .cpu_rdata(cpu_rdata),
        .card_rx_valid(card_rx_valid), .card_rx_byte(card_rx_byte),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_byte(card_tx_byte), .card_tx_ready(card_tx_ready),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .buf_af_flag(buf_af_flag), .buf_ae_flag(buf_ae_flag),
        .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [15:0] w);
        @(negedge clk); cfg_word = w; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic do_push(input logic [15:0] w);
        @(negedge clk); cpu_wdata = w; cpu_push = 1'b1;
        @(negedge clk); cpu_push = 1'b0;
    endtask

    task automatic do_pop(output logic [15:0] v);
        @(negedge clk); v = cpu_rdata; cpu_pop = 1'b1;
        @(negedge clk); cpu_pop = 1'b0;
    endtask

    task automatic do_start(input logic d, input int len_m1, input int num_m1);
        @(negedge clk);
        xfer_dir = d; blk_len_m1 = 11'(len_m1); blk_num_m1 = 11'(num_m1);
        xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    // offer one card byte; called at a falling edge
    task automatic feed(input logic [7:0] b, input bit last);
        card_rx_valid = 1'b1; card_rx_byte = b;
        while (!card_rx_ready) @(negedge clk);
        @(negedge clk); card_rx_valid = 1'b0;
        chk(last ? "R10 done on last byte" : "R10 no early done", int'(xfer_done), int'(last));
    endtask

    task automatic rd_xfer(input int len_m1, input int num_m1, input bit rx_en, input bit inject);
        logic [15:0] expw[$];
        logic [15:0] v;
        logic [7:0]  lo, b;
        int          w;
        do_cfg(16'h1F00);
        do_start(1'b1, len_m1, num_m1);
        for (int k = 0; k <= num_m1; k++) begin
            for (int i = 0; i <= len_m1; i++) begin
                b = 8'($urandom);
                if (i % 2 == 0) begin
                    lo = b;
                    if (i == len_m1) expw.push_back({8'h00, b});
                end else begin
                    expw.push_back({b, lo});
                end
                feed(b, (k == num_m1) && (i == len_m1));
                if (inject && k == 0 && i == 0) do_push(16'hDEAD); // R13
            end
        end
        chk("R10 rx idle after done", int'(card_rx_ready), 0);
        w = expw.size();
        do_cfg({rx_en, 2'b00, 5'(w - 1), 8'h00});
        chk("R5 rx req above level", int'(rx_dma_req), int'(rx_en));
        chk("R5 af flag above level", int'(buf_af_flag), int'(!rx_en));
        do_cfg({rx_en, 2'b00, 5'(w), 8'h00});
        chk("R5 quiet at level", int'(rx_dma_req | buf_af_flag), 0);
        for (int i = 0; i < w; i++) begin
            do_pop(v);
            chk("R8 packed word", int'(v), int'(expw[i]));
        end
        do_cfg(16'h0000);
        chk("R13 no stray word", int'(buf_af_flag), 0);
    endtask

    task automatic wr_xfer(input int len_m1, input int num_m1, input bit tx_en, input bit inject);
        logic [15:0] words[$];
        logic [7:0]  expb[$];
        logic [15:0] wv;
        int          wpb, total, got;
        bit          fire, stall, popped;
        logic [7:0]  held;
        wpb = (len_m1 + 2) / 2;
        do_cfg({8'h00, tx_en, 2'b00, 5'd4});
        do_start(1'b0, len_m1, num_m1);
        chk("R6 tx req below level", int'(tx_dma_req), int'(tx_en));
        chk("R6 ae flag below level", int'(buf_ae_flag), int'(!tx_en));
        chk("R11 no tx when empty", int'(card_tx_valid), 0);
        for (int i = 0; i < wpb * (num_m1 + 1); i++) begin
            wv = 16'($urandom);
            words.push_back(wv);
            do_push(wv);
        end
        if (words.size() >= 4) chk("R6 quiet at level", int'(tx_dma_req | buf_ae_flag), 0);
        for (int k = 0; k <= num_m1; k++)
            for (int i = 0; i <= len_m1; i++) begin
                wv = words[k * wpb + i / 2];
                expb.push_back((i % 2) ? wv[15:8] : wv[7:0]);
            end
        total = expb.size(); got = 0; fire = 0; stall = 0; popped = 0; held = '0;
        while (got < total) begin
            @(negedge clk);
            cpu_pop = 1'b0;
            if (fire) chk("R10 no early done", int'(xfer_done), 0);
            if (stall) chk("R14 byte held", int'(card_tx_byte), int'(held));
            card_tx_ready = 1'($urandom_range(0, 1));
            if (inject && got == 1 && !popped) begin
                cpu_pop = 1'b1; popped = 1; // R13
            end
            fire  = card_tx_valid && card_tx_ready;
            stall = card_tx_valid && !card_tx_ready;
            held  = card_tx_byte;
            if (fire) begin
                chk("R9 byte order", int'(card_tx_byte), int'(expb[got]));
                got++;
            end
        end
        @(negedge clk);
        cpu_pop = 1'b0; card_tx_ready = 1'b0;
        chk("R10 done after last byte", int'(xfer_done), 1);
        @(negedge clk);
        chk("R10 single pulse", int'(xfer_done), 0);
        chk("R10 tx idle after done", int'(card_tx_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] wq[$];
        logic [15:0] v;
        int          k;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset quiet", int'({rx_dma_req, tx_dma_req, buf_af_flag, buf_ae_flag,
                                    xfer_done, card_tx_valid, card_rx_ready}), 0);

        // idle queue: capacity, empty pop, idle thresholds
        do_cfg(16'h001F);
        chk("R7 idle empty quiet", int'(buf_ae_flag), 0);
        wq.push_back(16'($urandom));
        do_push(wq[0]);
        chk("R6 ae flag when non-empty", int'(buf_ae_flag), 1);
        do_cfg(16'h009F);
        chk("R4 tx dma enable bit 7", int'(tx_dma_req), 1);
        chk("R4 flag steered away", int'(buf_ae_flag), 0);
        do_cfg(16'h001F);
        for (int i = 1; i < 33; i++) begin
            wq.push_back(16'($urandom));
            do_push(wq[i]);
        end
        for (int i = 0; i < 32; i++) begin
            do_pop(v);
            chk("R2 order and depth", int'(v), int'(wq[i]));
        end
        chk("R7 idle empty quiet", int'(buf_ae_flag | tx_dma_req), 0);
        do_pop(v);
        chk("R3 empty pop shows head", int'(v), int'(wq[0]));
        chk("R3 head unchanged", int'(cpu_rdata), int'(wq[0]));

        // R12: start discards queued words and latches direction
        do_push(16'h1234);
        do_start(1'b1, 1, 0);
        do_cfg(16'h0000);
        chk("R12 start empties", int'(buf_af_flag), 0);
        feed(8'h11, 1'b0);
        feed(8'h22, 1'b1);
        chk("R12 direction latched", int'(buf_af_flag), 1);
        do_pop(v);
        chk("R8 two-byte word", int'(v), 16'h2211);

        // R11: fill stops above almost-full level
        do_cfg(16'h0200);
        do_start(1'b1, 9, 0);
        k = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            card_rx_valid = 1'b1; card_rx_byte = 8'(k);
            if (card_rx_ready) k++;
        end
        @(negedge clk); card_rx_valid = 1'b0;
        chk("R11 fill held at level", k, 6);
        chk("R5 af flag during hold", int'(buf_af_flag), 1);
        do_cfg(16'h1F00);
        for (int i = 6; i < 10; i++) feed(8'(i), i == 9);
        for (int i = 0; i < 5; i++) begin
            do_pop(v);
            chk("R8 packed after hold", int'(v), int'({8'(2*i+1), 8'(2*i)}));
        end

        // directed odd and single-byte blocks, then random mixes
        rd_xfer(0, 2, 1'b1, 1'b1);
        wr_xfer(2, 1, 1'b0, 1'b1);
        for (int r = 0; r < 3; r++) begin
            rd_xfer($urandom_range(0, 9), $urandom_range(0, 2), 1'($urandom), 1'($urandom));
            wr_xfer($urandom_range(0, 9), $urandom_range(0, 2), 1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule